// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a simple host request port to a single-data-rate synchronous DRAM that has four banks and a 16-bit data path. After reset it waits out the power-up hold-off. It then precharges every bank, runs a fixed number of auto refresh cycles and writes the mode register. From that point it serves one host access at a time and works on a closed-row basis. Each access opens its row, issues a single read or write with automatic precharge requested, and waits until the bank is free again. An interval counter raises a refresh request at a fixed cadence, and a pending refresh is served before any new host access.

The host hands over a word address, write data and byte enables through a valid/ready handshake. Read data comes back with a one-cycle valid strobe, captured exactly the programmed CAS latency after the memory takes the read command. The DRAM data bus is brought out as separate in, out and output-enable signals for an outer pad ring.

The controller is a state machine. Power-up: `ST_PWRUP` goes to `ST_PALL` (precharge all) when the hold-off timer expires. `ST_PALL` goes to `ST_PALL_W`, then `ST_IREF` and `ST_IREF_W`. These two repeat until the initial refreshes are done, and then `ST_MRS` and `ST_MRS_W` lead to `ST_IDLE`. From `ST_IDLE` a pending refresh goes to `ST_REF` and then `ST_REF_W`. An accepted request goes to `ST_ACT` and `ST_RCD`, then to either `ST_RD` and `ST_RD_W` or `ST_WR` and `ST_WR_W`. Every wait state returns to its successor when the shared down-counter reaches zero.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset is released, the controller issues nothing but deselect (chip select high) for at least INIT_WAIT_CYC cycles. req_ready stays low during that time.
- R2: The first commands after the hold-off are, in order: precharge with sd_addr[10]=1, then INIT_REFS auto refreshes, then a mode set whose address word is CAS_LAT<<4 (burst length one, sequential wrap). Only after these is req_ready raised.
- R3: Commands use {cs_n,ras_n,cas_n,we_n}: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode set 0000, no-op 0111. Deselect has cs_n=1.
- R4: The request address splits as bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. The activate drives the bank and row, and the read or write drives the column on sd_addr[8:0].
- R5: A read or write follows its activate by exactly T_RCD cycles and always carries sd_addr[10]=1, which requests automatic precharge.
- R6: Read data is captured from sd_dq_in at the edge CAS_LAT cycles after the edge at which the memory samples the read. It is then presented on rd_data with rd_valid high for exactly one cycle.
- R7: sd_dq_oe is high only in the write command cycle. In that cycle sd_dq_out carries the write data and sd_dqm equals the inverted byte enables.
- R8: The next command is held off by at least T_RP after a precharge, T_RFC after a refresh, CAS_LAT+T_RP after a read and T_WR+T_RP after a write. The data bus is therefore idle before any write follows a read.
- R9: With the controller idle, refreshes occur exactly every REF_INTERVAL cycles. A pending refresh wins over a waiting host request once the current access has finished.
- R10: CKE is always high, so the self-refresh entry pattern (refresh strobes with CKE low) never appears.
- R11: A request accepted with req_valid and req_ready both high is followed by its activate in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address: bank, row, column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 16 | Captured read data |
| sd_cke | output | 1 | Clock enable to DRAM |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte masks, 1 = masked |
| sd_dq_out | output | 16 | Write data to the pad |
| sd_dq_oe | output | 1 | Output enable for the data pad |
| sd_dq_in | input | 16 | Read data from the pad |

## Verification
The assertions check these on every cycle: CKE stays high and the self-refresh pattern never appears, the read strobe lags the read command by exactly the CAS latency, and each access command follows its activate by exactly T_RCD with automatic precharge requested. They also check that the data pad is driven only in write command cycles, that an accepted request is followed at once by an activate, and that nothing is issued in the cycle after a refresh. Some behaviours show only in the bench's scenarios: the length of the power-up hold-off, the exact initialisation order and mode word, the data written and read back through the address split and byte masks, the minimum command spacings, and the refresh cadence when idle and under a continuous stream of requests.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP, ST_PALL, ST_PALL_W, ST_IREF, ST_IREF_W, ST_MRS, ST_MRS_W,
        ST_IDLE, ST_REF, ST_REF_W, ST_ACT, ST_RCD, ST_RD, ST_RD_W, ST_WR, ST_WR_W
    } ctl_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sd_cmd_t;
    localparam sd_cmd_t CMD_DESL = 4'b1111;
    localparam sd_cmd_t CMD_NOP  = 4'b0111;
    localparam sd_cmd_t CMD_ACT  = 4'b0011;
    localparam sd_cmd_t CMD_RD   = 4'b0101;
    localparam sd_cmd_t CMD_WR   = 4'b0100;
    localparam sd_cmd_t CMD_PRE  = 4'b0010;
    localparam sd_cmd_t CMD_REF  = 4'b0001;
    localparam sd_cmd_t CMD_MRS  = 4'b0000;

endpackage

// File: rtl/sdr_dn_timer.sv
module sdr_dn_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sdr_ref_tick.sv
module sdr_ref_tick #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (tick) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CL   = 3,
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [DQ_W-1:0] dq_in,
    output logic            valid,
    output logic [DQ_W-1:0] data
);
    logic [CL-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            valid <= 1'b0;
        end else begin
            stage <= {stage[CL-2:0], issue};
            valid <= stage[CL-1];
        end
    end

    always_ff @(posedge clk) begin
        if (stage[CL-1]) begin
            data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdr_pkg::*;
#(
    parameter int BA_W          = 2,
    parameter int ROW_W         = 12,
    parameter int COL_W         = 9,
    parameter int DQ_W          = 16,
    parameter int CAS_LAT       = 3,
    parameter int T_RCD         = 2,
    parameter int T_RP          = 2,
    parameter int T_RFC         = 7,
    parameter int T_WR          = 2,
    parameter int T_MRD         = 2,
    parameter int INIT_REFS     = 2,
    parameter int INIT_WAIT_CYC = 10000,
    parameter int REF_INTERVAL  = 1560,
    localparam int ADDR_W       = BA_W + ROW_W + COL_W,
    localparam int BE_W         = DQ_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BE_W-1:0]   sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    localparam int AP_BIT  = 10;
    localparam int TMR_MAX = INIT_WAIT_CYC + T_RFC + T_WR + T_RP + T_RCD + CAS_LAT + T_MRD;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int IREF_W  = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    ctl_state_e state, state_nx;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              ref_pend;
    logic              ref_ack;
    logic              run_q;
    logic              accept;
    logic [IREF_W-1:0] iref_left;
    sd_cmd_t           cmd;

    logic              q_we;
    logic [BA_W-1:0]   q_ba;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic [DQ_W-1:0]   q_wd;
    logic [BE_W-1:0]   q_be;

    sdr_dn_timer #(.W(TMR_W), .RST_VAL(INIT_WAIT_CYC - 1)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sdr_ref_tick #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .run(run_q), .ack(ref_ack), .pend(ref_pend)
    );

    sdr_rd_capture #(.CL(CAS_LAT), .DQ_W(DQ_W)) u_cap (
        .clk(clk), .rst(rst), .issue(state == ST_RD), .dq_in(sd_dq_in),
        .valid(rd_valid), .data(rd_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PWRUP;
        end else begin
            state <= state_nx;
        end
    end

    // next state and timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        unique case (state)
            ST_PWRUP:  if (tmr_zero) state_nx = ST_PALL;
            ST_PALL: begin
                state_nx = ST_PALL_W;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RP - 2);
            end
            ST_PALL_W: if (tmr_zero) state_nx = ST_IREF;
            ST_IREF: begin
                state_nx = ST_IREF_W;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RFC - 2);
            end
            ST_IREF_W: if (tmr_zero) state_nx = (iref_left == '0) ? ST_MRS : ST_IREF;
            ST_MRS: begin
                state_nx = ST_MRS_W;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_MRD - 2);
            end
            ST_MRS_W:  if (tmr_zero) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (ref_pend) begin
                    state_nx = ST_REF;
                end else if (req_valid) begin
                    state_nx = ST_ACT;
                    accept   = 1'b1;
                end
            end
            ST_REF: begin
                state_nx = ST_REF_W;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RFC - 2);
            end
            ST_REF_W:  if (tmr_zero) state_nx = ST_IDLE;
            ST_ACT: begin
                state_nx = ST_RCD;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RCD - 2);
            end
            ST_RCD:    if (tmr_zero) state_nx = q_we ? ST_WR : ST_RD;
            ST_RD: begin
                state_nx = ST_RD_W;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CAS_LAT + T_RP - 2);
            end
            ST_RD_W:   if (tmr_zero) state_nx = ST_IDLE;
            ST_WR: begin
                state_nx = ST_WR_W;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_WR + T_RP - 2);
            end
            ST_WR_W:   if (tmr_zero) state_nx = ST_IDLE;
        endcase
    end

    // request latch, init refresh count, run flag
    always_ff @(posedge clk) begin
        if (rst) begin
            q_we      <= 1'b0;
            q_ba      <= '0;
            q_row     <= '0;
            q_col     <= '0;
            q_wd      <= '0;
            q_be      <= '0;
            iref_left <= IREF_W'(INIT_REFS);
            run_q     <= 1'b0;
        end else begin
            if (accept) begin
                q_we  <= req_we;
                q_ba  <= req_addr[ADDR_W-1 -: BA_W];
                q_row <= req_addr[COL_W +: ROW_W];
                q_col <= req_addr[COL_W-1:0];
                q_wd  <= req_wdata;
                q_be  <= req_be;
            end
            if (state == ST_IREF) begin
                iref_left <= iref_left - 1'b1;
            end
            if (state == ST_MRS_W && tmr_zero) begin
                run_q <= 1'b1;
            end
        end
    end

    assign ref_ack   = (state == ST_REF);
    assign req_ready = (state == ST_IDLE) && !ref_pend;

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        sd_dqm    = '1;
        sd_dq_out = '0;
        sd_dq_oe  = 1'b0;
        unique case (state)
            ST_PWRUP: cmd = CMD_DESL;
            ST_PALL: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_IREF, ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd     = CMD_MRS;
                sd_addr = MODE_WORD;
            end
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = q_ba;
                sd_addr = q_row;
            end
            ST_RD: begin
                cmd                  = CMD_RD;
                sd_ba                = q_ba;
                sd_addr[COL_W-1:0]   = q_col;
                sd_addr[AP_BIT]      = 1'b1;
                sd_dqm               = '0;
            end
            ST_RD_W: sd_dqm = '0;
            ST_WR: begin
                cmd                  = CMD_WR;
                sd_ba                = q_ba;
                sd_addr[COL_W-1:0]   = q_col;
                sd_addr[AP_BIT]      = 1'b1;
                sd_dqm               = ~q_be;
                sd_dq_out            = q_wd;
                sd_dq_oe             = 1'b1;
            end
            ST_PALL_W, ST_IREF_W, ST_MRS_W, ST_IDLE, ST_REF_W,
            ST_RCD, ST_WR_W: cmd = CMD_NOP;
        endcase
    end

    assign sd_cke   = 1'b1;
    assign sd_cs_n  = cmd[3];
    assign sd_ras_n = cmd[2];
    assign sd_cas_n = cmd[1];
    assign sd_we_n  = cmd[0];
endmodule

// File: rtl/sdr_seq_ctrl_chk.sv
module sdr_seq_ctrl_chk #(
    parameter int CAS_LAT = 3,
    parameter int T_RCD   = 2,
    parameter int ROW_W   = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             sd_cke,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             sd_dq_oe
);
    logic [3:0] c;
    logic is_rd, is_wr, is_act, is_ref, is_idle_cmd;

    assign c           = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_rd       = (c == 4'b0101);
    assign is_wr       = (c == 4'b0100);
    assign is_act      = (c == 4'b0011);
    assign is_ref      = (c == 4'b0001);
    assign is_idle_cmd = sd_cs_n || (c == 4'b0111);

    p_no_selfref_r10: assert property (@(posedge clk) disable iff (rst)
        sd_cke && !(c == 4'b0001 && !sd_cke));

    p_rd_latency_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid == $past(is_rd, CAS_LAT + 1));

    p_act_to_rw_r5: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> $past(is_act, T_RCD));

    p_autopre_r5: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> sd_addr[10]);

    p_oe_write_r7: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> is_wr);

    p_accept_act_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> is_act);

    p_ref_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        is_ref |=> is_idle_cmd);
endmodule

bind sdram_seq_ctrl sdr_seq_ctrl_chk #(
    .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rd_valid(rd_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sim_sdram_seq_ctrl.sv
module sim_sdram_seq_ctrl;
    localparam int CL        = 3;
    localparam int T_RCD     = 2;
    localparam int T_RP      = 2;
    localparam int T_RFC     = 7;
    localparam int T_WR      = 2;
    localparam int IREFS     = 2;
    localparam int INIT_WAIT = 10000;
    localparam int REF_INT   = 1560;

    typedef struct packed {
        logic        we;
        logic [22:0] addr;
        logic [15:0] wd;
        logic [1:0]  be;
        logic [15:0] ex;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 23'h000010, 16'h1234, 2'b11, 16'h0000},
        '{1'b1, {2'b11, 12'hABC, 9'h1FF}, 16'hBEEF, 2'b11, 16'h0000},
        '{1'b1, 23'h200020, 16'h995A, 2'b01, 16'h0000},
        '{1'b0, 23'h000010, 16'h0000, 2'b11, 16'h1234},
        '{1'b0, {2'b11, 12'hABC, 9'h1FF}, 16'h0000, 2'b11, 16'hBEEF},
        '{1'b0, 23'h200020, 16'h0000, 2'b11, 16'h005A},
        '{1'b1, 23'h200020, 16'hC3FF, 2'b10, 16'h0000},
        '{1'b0, 23'h200020, 16'h0000, 2'b11, 16'hC35A}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hDEAD;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_seq_ctrl #(
        .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR),
        .INIT_REFS(IREFS), .INIT_WAIT_CYC(INIT_WAIT), .REF_INTERVAL(REF_INT)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model and port monitor ----------------
    logic [15:0] mem [int];
    logic [11:0] open_row [4];
    bit          rp_v [CL];
    int          rp_k [CL];
    int   cyc = 0, last_cyc = 0, act_cyc = 0, first_cmd = -1;
    logic [3:0]  last_cmd = 4'b0111;
    logic [3:0]  init_cmd [4];
    logic [11:0] init_adr [4];
    int   n_cmd = 0;
    bit   post_init = 0, exp_act = 0;
    int   v_cke = 0, v_oe = 0, v_acc = 0, v_gap = 0, v_rcd = 0, v_ap = 0, v_map = 0, v_wr = 0;
    int   ref_cnt = 0, prev_ref = -1, last_gap = 0, max_gap = 0;
    logic [1:0]  exp_ba;
    logic [11:0] exp_row;
    logic [15:0] exp_wd;
    logic [1:0]  exp_be;

    function automatic int min_gap(input logic [3:0] c);
        case (c)
            4'b0010: return T_RP;
            4'b0001: return T_RFC;
            4'b0101: return CL + T_RP;
            4'b0100: return T_WR + T_RP;
            4'b0011: return T_RCD;
            default: return 2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            for (int i = 0; i < CL; i++) rp_v[i] = 0;
        end else begin
            logic [3:0] c;
            int key;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!sd_cke) v_cke++;
            if (sd_dq_oe && c != 4'b0100) v_oe++;
            if (exp_act && c != 4'b0011) v_acc++;
            exp_act = req_valid && req_ready;
            key = {sd_ba, open_row[sd_ba], sd_addr[8:0]};
            if (rp_v[CL-2]) sd_dq_in <= mem.exists(rp_k[CL-2]) ? mem[rp_k[CL-2]] : 16'h0000;
            else            sd_dq_in <= 16'hDEAD;
            for (int i = CL - 1; i > 0; i--) begin
                rp_v[i] = rp_v[i-1];
                rp_k[i] = rp_k[i-1];
            end
            rp_v[0] = (c == 4'b0101);
            rp_k[0] = key;
            if (!sd_cs_n && c != 4'b0111) begin
                if (first_cmd < 0) first_cmd = cyc;
                if (n_cmd > 0 && (cyc - last_cyc) < min_gap(last_cmd)) v_gap++;
                if (n_cmd < 4) begin
                    init_cmd[n_cmd] = c;
                    init_adr[n_cmd] = sd_addr;
                end
                n_cmd++;
                case (c)
                    4'b0011: begin
                        open_row[sd_ba] = sd_addr;
                        act_cyc = cyc;
                        if (sd_ba != exp_ba || sd_addr != exp_row) v_map++;
                    end
                    4'b0101: begin
                        if (cyc - act_cyc != T_RCD) v_rcd++;
                        if (!sd_addr[10]) v_ap++;
                    end
                    4'b0100: begin
                        logic [15:0] w;
                        if (cyc - act_cyc != T_RCD) v_rcd++;
                        if (!sd_addr[10]) v_ap++;
                        if (sd_dqm != ~exp_be || sd_dq_out != exp_wd) v_wr++;
                        w = mem.exists(key) ? mem[key] : 16'h0000;
                        if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
                        if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                        mem[key] = w;
                    end
                    4'b0001: if (post_init) begin
                        if (prev_ref >= 0) begin
                            last_gap = cyc - prev_ref;
                            if (last_gap > max_gap) max_gap = last_gap;
                        end
                        prev_ref = cyc;
                        ref_cnt++;
                    end
                    4'b0000: post_init = 1;
                    default: ;
                endcase
                last_cmd = c;
                last_cyc = cyc;
            end
            cyc++;
        end
    end

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = v.we;
        req_addr  = v.addr;
        req_wdata = v.wd;
        req_be    = v.be;
        exp_ba    = v.addr[22:21];
        exp_row   = v.addr[20:9];
        exp_wd    = v.wd;
        exp_be    = v.be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input vec_t v, input bit check);
        int t;
        issue(v);
        t = 0;
        while (!rd_valid && t < 40) begin
            @(negedge clk);
            t++;
        end
        if (check) begin
            chk(rd_valid && rd_data == v.ex, "R6 read data", {16'h0, rd_data}, {16'h0, v.ex});
            @(negedge clk);
            chk(!rd_valid, "R6 single-cycle strobe", {31'h0, rd_valid}, 32'h0);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        int t;
        int rc0;
        repeat (5) @(negedge clk);
        chk(sd_cs_n && !req_ready && !sd_dq_oe && !rd_valid && sd_cke, "R1 reset state",
            {27'h0, sd_cs_n, req_ready, sd_dq_oe, rd_valid, sd_cke}, 32'h11);
        rst = 1'b0;
        t = 0;
        while (!req_ready && t < INIT_WAIT + 200) begin
            @(negedge clk);
            t++;
        end
        chk(req_ready, "R2 ready after init", {31'h0, req_ready}, 32'h1);
        chk(first_cmd >= INIT_WAIT, "R1 hold-off", first_cmd, INIT_WAIT);
        chk(init_cmd[0] == 4'b0010 && init_adr[0][10], "R2 precharge all first",
            {init_adr[0], init_cmd[0]}, {12'h400, 4'b0010});
        chk(init_cmd[1] == 4'b0001 && init_cmd[2] == 4'b0001, "R2 init refreshes",
            {init_cmd[1], init_cmd[2]}, 8'h11);
        chk(init_cmd[3] == 4'b0000 && init_adr[3] == 12'(CL << 4), "R3 mode set word",
            {init_adr[3], init_cmd[3]}, {12'(CL << 4), 4'b0000});

        // vector table: writes, partial writes, read-back, write after read
        foreach (VECS[i]) begin
            if (VECS[i].we) begin
                issue(VECS[i]);
                repeat (T_RCD + T_WR + T_RP + 2) @(negedge clk);
            end else begin
                do_read(VECS[i], 1'b1);
            end
        end

        // R9 idle cadence
        rc0 = ref_cnt;
        repeat (3 * REF_INT + 40) @(negedge clk);
        chk(ref_cnt - rc0 >= 2, "R9 idle refresh count", ref_cnt - rc0, 2);
        chk(last_gap == REF_INT, "R9 idle refresh spacing", last_gap, REF_INT);

        // R9 priority under continuous reads
        max_gap = 0;
        rc0 = ref_cnt;
        t = cyc;
        while (cyc - t < 2 * REF_INT + 100) do_read(VECS[3], 1'b0);
        chk(ref_cnt - rc0 >= 2, "R9 refresh under load", ref_cnt - rc0, 2);
        chk(max_gap <= REF_INT + 20, "R9 refresh priority gap", max_gap, REF_INT + 20);
        do_read(VECS[7], 1'b1);

        repeat (10) @(negedge clk);
        chk(v_cke == 0, "R10 cke low / self-refresh", v_cke, 0);
        chk(v_oe == 0, "R7 oe outside write", v_oe, 0);
        chk(v_wr == 0, "R7 write data and dqm", v_wr, 0);
        chk(v_acc == 0, "R11 activate after accept", v_acc, 0);
        chk(v_gap == 0, "R8 command spacing", v_gap, 0);
        chk(v_rcd == 0, "R5 activate to access", v_rcd, 0);
        chk(v_ap == 0, "R5 auto precharge bit", v_ap, 0);
        chk(v_map == 0, "R4 bank/row mapping", v_map, 0);
        done = 1'b1;
        summary();
    end
endmodule